// File: doc/BRIEF.md
# Kernel Launch and Halt-Status Controller

This block is the control front of an accelerator. A host reaches it through an AXI-Lite slave port. It launches a compute core, tracks whether that core is running, and reports completion through a done word that the host polls. The core itself is not part of the block. It receives a one-cycle launch pulse and answers with a one-cycle return pulse. When the core stops on an error, it raises a halt pulse that carries an error code and a 16-bit transaction id. The block holds these until the host clears them.

The word map is fixed. The start trigger sits at 0x00 and the done flag at 0x04, ahead of all user fields. The user fields are: a status-clear word at 0x08, the halted flag at 0x0C, the error code at 0x10, the failing transaction id at 0x14, and four read-write coefficient words at 0x18, 0x1C, 0x20 and 0x24. The coefficients also drive the core directly.

A typical host session has four steps. Write the coefficients. Write 1 to the start word. Poll the done word until it reads 1. If the core stopped on an error, read the halted flag, the error code and the id, then write 1 to the status-clear word before launching again.

Top module: `kcl_launch_ctrl`

## Requirements
- R1: After reset, busy_o is 0, no launch pulse is issued, no response is pending, and every register reads 0: done, halted, error code, id and all coefficients.
- R2: A write whose data bit 0 is 1 to byte offset 0x00, made while idle, does three things. It produces exactly one launch pulse, one cycle long, on core_launch_o. It sets busy_o. It makes the done word at 0x04 read 0 until the core returns.
- R3: A write of 1 to 0x00 made while busy_o is 1 is dropped: no launch pulse is issued and busy_o stays 1.
- R4: The start word at 0x00 always reads 0, because it clears itself. A write to 0x00 with data bit 0 equal to 0 launches nothing.
- R5: A core_ret_i pulse while busy sets done (0x04 reads 1) and clears busy_o. A core_ret_i pulse while idle has no effect.
- R6: Each accepted launch clears done back to 0.
- R7: A core_halt_i pulse latches three values: halted (0x0C reads 1), core_err_i into 0x10, and core_txid_i into 0x14. The error codes are 0 none, 1 header ended early, 2 header end missing, 3 samples ended early, 4 samples end missing, and 5 wrong sample count. If a halt pulse and a status-clear write land in the same cycle, the halt wins.
- R8: A write with data bit 0 equal to 1 at 0x08 clears both halted and the error code to 0 and leaves the id unchanged. A write of 0 there changes nothing. The word at 0x08 reads 0.
- R9: The four coefficient words at 0x18 through 0x24 read back the last value written to them. They appear on coef_o, with word k at bits [32k+31:32k].
- R10: The following accesses have no effect on any register. They complete with an OKAY response, and the reads return 0.
  - Writes to read-only words (0x04, 0x0C, 0x10, 0x14).
  - Writes to unmapped offsets.
  - Writes to offsets that are not 4-byte aligned.
  - Reads of unmapped or unaligned offsets.
- R11: Each write is accepted when the address and data are presented together. The write response stays valid with OKAY until bready is seen. Each read returns its data one cycle after acceptance, and the data is held stable until rready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| core_launch_o | output | 1 | One-cycle launch pulse to the core |
| core_ret_i | input | 1 | One-cycle return pulse from the core |
| core_halt_i | input | 1 | One-cycle halt report from the core |
| core_err_i | input | ERR_W | Error code carried with the halt report |
| core_txid_i | input | ID_W | Failing transaction id carried with the halt report |
| busy_o | output | 1 | Core is running |
| coef_o | output | N_COEF*32 | Coefficient words, word k at bits [32k+31:32k] |

## Verification
A wrong busy state shows up within one cycle of the next start write. It appears either as a launch pulse that should have been dropped or as a missing one. The done word keeps the wrong value until the following launch or return. A halt latch that is lost, or cleared too early, shows up on the very next read of 0x0C or 0x10. A decode slip shows up in two ways: a read-only or unaligned write that lands in a neighbouring word, or a coefficient read-back that does not match what was written.

// File: rtl/kcl_pkg.sv
package kcl_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [3:0] {
    W_START  = 4'd0,
    W_DONE   = 4'd1,
    W_STCLR  = 4'd2,
    W_HALTED = 4'd3,
    W_ERR    = 4'd4,
    W_TXID   = 4'd5,
    W_COEF0  = 4'd6
  } word_e;

  typedef enum logic [2:0] {
    ERR_NONE       = 3'd0,
    ERR_HDR_EARLY  = 3'd1,
    ERR_HDR_NOEND  = 3'd2,
    ERR_SMP_EARLY  = 3'd3,
    ERR_SMP_NOEND  = 3'd4,
    ERR_BAD_COUNT  = 3'd5
  } err_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/kcl_axil_port.sv
module kcl_axil_port #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  output logic              awready,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wvalid,
  output logic              wready,
  output logic [1:0]        bresp,
  output logic              bvalid,
  input  logic              bready,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  output logic              arready,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rvalid,
  input  logic              rready,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [DATA_W-1:0] wr_data,
  output logic [IDX_W-1:0]  rd_idx,
  input  logic [DATA_W-1:0] rd_word
);
  logic              bvalid_q, bvalid_d;
  logic              rvalid_q, rvalid_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              wr_take, rd_take, rd_en;

  // write path: address and data accepted together, one response outstanding
  always_comb begin
    wr_take  = awvalid && wvalid && !bvalid_q;
    wr_en    = wr_take && (awaddr[1:0] == 2'b00);
    wr_idx   = awaddr[ADDR_W-1:2];
    wr_data  = wdata;
    bvalid_d = bvalid_q;
    if (wr_take)     bvalid_d = 1'b1;
    else if (bready) bvalid_d = 1'b0;
  end

  // read path: one cycle from acceptance to data
  always_comb begin
    rd_take  = arvalid && !rvalid_q;
    rd_en    = rd_take && (araddr[1:0] == 2'b00);
    rd_idx   = araddr[ADDR_W-1:2];
    rvalid_d = rvalid_q;
    rdata_d  = rdata_q;
    if (rd_take) begin
      rvalid_d = 1'b1;
      rdata_d  = rd_en ? rd_word : '0;
    end else if (rready) begin
      rvalid_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bvalid_q <= 1'b0;
      rvalid_q <= 1'b0;
      rdata_q  <= '0;
    end else begin
      bvalid_q <= bvalid_d;
      rvalid_q <= rvalid_d;
      if (rd_take) rdata_q <= rdata_d;
    end
  end

  assign awready = wr_take;
  assign wready  = wr_take;
  assign bvalid  = bvalid_q;
  assign bresp   = kcl_pkg::RESP_OKAY;
  assign arready = !rvalid_q;
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = kcl_pkg::RESP_OKAY;
endmodule

// File: rtl/kcl_launch.sv
module kcl_launch (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic ret_i,
  output logic launch_o,
  output logic busy_o,
  output logic done_o
);
  logic busy_q, busy_d;
  logic done_q, done_d;
  logic launch_q, launch_d;

  always_comb begin
    busy_d   = busy_q;
    done_d   = done_q;
    launch_d = 1'b0;
    if (start_req && !busy_q) begin
      busy_d   = 1'b1;
      done_d   = 1'b0;
      launch_d = 1'b1;
    end else if (ret_i && busy_q) begin
      busy_d = 1'b0;
      done_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      launch_q <= 1'b0;
    end else begin
      busy_q   <= busy_d;
      done_q   <= done_d;
      launch_q <= launch_d;
    end
  end

  assign launch_o = launch_q;
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/kcl_status.sv
module kcl_status #(
  parameter int ERR_W = 3,
  parameter int ID_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt_i,
  input  logic [ERR_W-1:0] code_i,
  input  logic [ID_W-1:0]  id_i,
  input  logic             clr_req,
  output logic             halted_o,
  output logic [ERR_W-1:0] code_o,
  output logic [ID_W-1:0]  id_o
);
  logic             halted_q, halted_d;
  logic [ERR_W-1:0] code_q, code_d;
  logic [ID_W-1:0]  id_q, id_d;

  // a halt report outranks a same-cycle clear from the host
  always_comb begin
    halted_d = halted_q;
    code_d   = code_q;
    id_d     = id_q;
    if (halt_i) begin
      halted_d = 1'b1;
      code_d   = code_i;
      id_d     = id_i;
    end else if (clr_req) begin
      halted_d = 1'b0;
      code_d   = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted_q <= 1'b0;
      code_q   <= '0;
      id_q     <= '0;
    end else begin
      halted_q <= halted_d;
      code_q   <= code_d;
      id_q     <= id_d;
    end
  end

  assign halted_o = halted_q;
  assign code_o   = code_q;
  assign id_o     = id_q;
endmodule

// File: rtl/kcl_launch_ctrl.sv
module kcl_launch_ctrl #(
  parameter int ADDR_W = 8,
  parameter int N_COEF = 4,
  parameter int ERR_W  = 3,
  parameter int ID_W   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    s_awaddr,
  input  logic                 s_awvalid,
  output logic                 s_awready,
  input  logic [31:0]          s_wdata,
  input  logic                 s_wvalid,
  output logic                 s_wready,
  output logic [1:0]           s_bresp,
  output logic                 s_bvalid,
  input  logic                 s_bready,
  input  logic [ADDR_W-1:0]    s_araddr,
  input  logic                 s_arvalid,
  output logic                 s_arready,
  output logic [31:0]          s_rdata,
  output logic [1:0]           s_rresp,
  output logic                 s_rvalid,
  input  logic                 s_rready,
  output logic                 core_launch_o,
  input  logic                 core_ret_i,
  input  logic                 core_halt_i,
  input  logic [ERR_W-1:0]     core_err_i,
  input  logic [ID_W-1:0]      core_txid_i,
  output logic                 busy_o,
  output logic [N_COEF*32-1:0] coef_o
);
  import kcl_pkg::*;
  localparam int IDX_W = ADDR_W - 2;

  logic              rst_meta, rst_sync_n;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx, rd_idx;
  logic [DATA_W-1:0] wr_data, rd_word;
  logic              start_req, clr_req;
  logic              done_w, halted_w;
  logic [ERR_W-1:0]  err_w;
  logic [ID_W-1:0]   txid_w;
  logic [DATA_W-1:0] coef_q [N_COEF];

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  kcl_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) port_i (
    .clk(clk), .rst_n(rst_sync_n),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wvalid(s_wvalid), .wready(s_wready),
    .bresp(s_bresp), .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rresp(s_rresp), .rvalid(s_rvalid), .rready(s_rready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  assign start_req = wr_en && (wr_idx == IDX_W'(W_START)) && wr_data[0];
  assign clr_req   = wr_en && (wr_idx == IDX_W'(W_STCLR)) && wr_data[0];

  kcl_launch launch_i (
    .clk(clk), .rst_n(rst_sync_n),
    .start_req(start_req), .ret_i(core_ret_i),
    .launch_o(core_launch_o), .busy_o(busy_o), .done_o(done_w)
  );

  kcl_status #(.ERR_W(ERR_W), .ID_W(ID_W)) status_i (
    .clk(clk), .rst_n(rst_sync_n),
    .halt_i(core_halt_i), .code_i(core_err_i), .id_i(core_txid_i),
    .clr_req(clr_req),
    .halted_o(halted_w), .code_o(err_w), .id_o(txid_w)
  );

  generate
    for (genvar k = 0; k < N_COEF; k++) begin : g_coef
      logic we;
      assign we = wr_en && (wr_idx == IDX_W'(int'(W_COEF0) + k));
      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n)  coef_q[k] <= '0;
        else if (we)      coef_q[k] <= wr_data;
      end
      assign coef_o[k*32 +: 32] = coef_q[k];
    end
  endgenerate

  always_comb begin
    rd_word = '0;
    unique case (rd_idx)
      IDX_W'(W_DONE):   rd_word = DATA_W'(done_w);
      IDX_W'(W_HALTED): rd_word = DATA_W'(halted_w);
      IDX_W'(W_ERR):    rd_word = DATA_W'(err_w);
      IDX_W'(W_TXID):   rd_word = DATA_W'(txid_w);
      default: begin
        for (int k = 0; k < N_COEF; k++)
          if (rd_idx == IDX_W'(int'(W_COEF0) + k)) rd_word = coef_q[k];
      end
    endcase
  end
endmodule

// File: rtl/kcl_launch_ctrl_chk.sv
module kcl_launch_ctrl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        launch,
  input logic        busy,
  input logic        done,
  input logic        ret,
  input logic        halt,
  input logic        halted,
  input logic        bvalid,
  input logic        bready,
  input logic [1:0]  bresp,
  input logic        rvalid,
  input logic        rready,
  input logic [31:0] rdata
);
  p_launch_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |=> !launch);
  p_launch_sets_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> busy);
  p_no_launch_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !launch);
  p_ret_sets_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ret && !launch) |=> (done && !busy));
  p_launch_clears_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    launch |-> !done);
  p_halt_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> halted);
  p_bresp_okay_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bvalid |-> (bresp == 2'b00));
  p_bvalid_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bvalid && !bready) |=> bvalid);
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid && !rready) |=> (rvalid && $stable(rdata)));
endmodule

bind kcl_launch_ctrl kcl_launch_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_sync_n),
  .launch(core_launch_o), .busy(busy_o), .done(done_w), .ret(core_ret_i),
  .halt(core_halt_i), .halted(halted_w),
  .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
  .rvalid(s_rvalid), .rready(s_rready), .rdata(s_rdata)
);

// File: tb/kcl_launch_ctrl_tb.sv
module kcl_launch_ctrl_tb_top;
  localparam int ADDR_W = 8;
  localparam int N_COEF = 4;

  localparam logic [2:0] OP_WR = 3'd0, OP_RD = 3'd1, OP_RET = 3'd2,
                         OP_HALT = 3'd3, OP_LCNT = 3'd4, OP_BUSY = 3'd5;

  typedef struct packed {
    logic [2:0]  op;
    logic [3:0]  req;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 48;
  localparam logic [78:0] TBL [NV] = '{
    {OP_RD,   4'd1,  8'h04, 32'h0, 32'h0},          // R1 done at reset
    {OP_RD,   4'd1,  8'h0C, 32'h0, 32'h0},          // R1 halted at reset
    {OP_RD,   4'd1,  8'h18, 32'h0, 32'h0},          // R1 coef at reset
    {OP_WR,   4'd2,  8'h00, 32'h1, 32'h0},          // R2 launch
    {OP_LCNT, 4'd2,  8'h00, 32'h0, 32'h1},          // R2
    {OP_BUSY, 4'd2,  8'h00, 32'h0, 32'h1},          // R2
    {OP_RD,   4'd2,  8'h04, 32'h0, 32'h0},          // R2 poll before return
    {OP_RD,   4'd4,  8'h00, 32'h0, 32'h0},          // R4 start reads 0
    {OP_WR,   4'd3,  8'h00, 32'h1, 32'h0},          // R3 start while busy
    {OP_LCNT, 4'd3,  8'h00, 32'h0, 32'h1},          // R3
    {OP_BUSY, 4'd3,  8'h00, 32'h0, 32'h1},          // R3
    {OP_RET,  4'd5,  8'h00, 32'h0, 32'h0},          // R5 return
    {OP_RD,   4'd5,  8'h04, 32'h0, 32'h1},          // R5
    {OP_BUSY, 4'd5,  8'h00, 32'h0, 32'h0},          // R5
    {OP_RET,  4'd5,  8'h00, 32'h0, 32'h0},          // R5 return while idle
    {OP_BUSY, 4'd5,  8'h00, 32'h0, 32'h0},          // R5
    {OP_RD,   4'd5,  8'h04, 32'h0, 32'h1},          // R5
    {OP_WR,   4'd4,  8'h00, 32'h0, 32'h0},          // R4 write 0 to start
    {OP_LCNT, 4'd4,  8'h00, 32'h0, 32'h1},          // R4
    {OP_BUSY, 4'd4,  8'h00, 32'h0, 32'h0},          // R4
    {OP_WR,   4'd6,  8'h00, 32'h1, 32'h0},          // R6 relaunch
    {OP_LCNT, 4'd6,  8'h00, 32'h0, 32'h2},          // R6
    {OP_RD,   4'd6,  8'h04, 32'h0, 32'h0},          // R6 done cleared
    {OP_HALT, 4'd7,  8'h00, 32'h0003BEEF, 32'h0},   // R7 code 3, id BEEF
    {OP_RET,  4'd7,  8'h00, 32'h0, 32'h0},          // R7
    {OP_RD,   4'd7,  8'h0C, 32'h0, 32'h1},          // R7
    {OP_RD,   4'd7,  8'h10, 32'h0, 32'h3},          // R7
    {OP_RD,   4'd7,  8'h14, 32'h0, 32'hBEEF},       // R7
    {OP_WR,   4'd8,  8'h08, 32'h0, 32'h0},          // R8 write 0 to clear
    {OP_RD,   4'd8,  8'h0C, 32'h0, 32'h1},          // R8
    {OP_WR,   4'd8,  8'h08, 32'h1, 32'h0},          // R8 clear
    {OP_RD,   4'd8,  8'h0C, 32'h0, 32'h0},          // R8
    {OP_RD,   4'd8,  8'h10, 32'h0, 32'h0},          // R8
    {OP_RD,   4'd8,  8'h14, 32'h0, 32'hBEEF},       // R8 id kept
    {OP_WR,   4'd10, 8'h04, 32'hFFFF, 32'h0},       // R10 write done
    {OP_RD,   4'd10, 8'h04, 32'h0, 32'h1},          // R10
    {OP_WR,   4'd10, 8'h10, 32'h7, 32'h0},          // R10 write error
    {OP_RD,   4'd10, 8'h10, 32'h0, 32'h0},          // R10
    {OP_WR,   4'd9,  8'h18, 32'h11111111, 32'h0},   // R9
    {OP_WR,   4'd9,  8'h1C, 32'h22222222, 32'h0},   // R9
    {OP_WR,   4'd9,  8'h20, 32'h33333333, 32'h0},   // R9
    {OP_WR,   4'd9,  8'h24, 32'h44444444, 32'h0},   // R9
    {OP_RD,   4'd9,  8'h18, 32'h0, 32'h11111111},   // R9
    {OP_RD,   4'd9,  8'h24, 32'h0, 32'h44444444},   // R9
    {OP_WR,   4'd10, 8'h19, 32'hDEADBEEF, 32'h0},   // R10 unaligned write
    {OP_RD,   4'd10, 8'h18, 32'h0, 32'h11111111},   // R10
    {OP_RD,   4'd10, 8'h40, 32'h0, 32'h0},          // R10 unmapped read
    {OP_RD,   4'd8,  8'h08, 32'h0, 32'h0}           // R8 clear word reads 0
  };

  logic clk, rst_n;
  logic [ADDR_W-1:0] awaddr, araddr;
  logic awvalid, awready, wvalid, wready, bvalid, bready;
  logic arvalid, arready, rvalid, rready;
  logic [31:0] wdata, rdata;
  logic [1:0] bresp, rresp;
  logic launch, ret, halt, busy;
  logic [2:0] err;
  logic [15:0] txid;
  logic [N_COEF*32-1:0] coef;

  int total = 0, bad = 0, lcnt = 0;
  bit finished = 0;

  kcl_launch_ctrl #(.ADDR_W(ADDR_W), .N_COEF(N_COEF)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .core_launch_o(launch), .core_ret_i(ret), .core_halt_i(halt),
    .core_err_i(err), .core_txid_i(txid), .busy_o(busy), .coef_o(coef)
  );

  initial clk = 0;
  always #2 clk = ~clk;

  always @(posedge clk) if (launch) lcnt++;

  task automatic check(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic do_wr(input int req, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    awaddr = a; wdata = d; awvalid = 1; wvalid = 1;
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0;
    check(11, "bvalid after write", {31'b0, bvalid}, 32'h1);
    check(req, "bresp okay", {30'b0, bresp}, 32'h0);
    @(posedge clk);
    @(negedge clk);
    check(11, "bvalid held", {31'b0, bvalid}, 32'h1);
    bready = 1;
    @(posedge clk);
    @(negedge clk);
    bready = 0;
  endtask

  task automatic do_rd(input int req, input logic [7:0] a, input logic [31:0] exp);
    @(negedge clk);
    araddr = a; arvalid = 1;
    @(posedge clk);
    @(negedge clk);
    arvalid = 0;
    check(11, "rvalid", {31'b0, rvalid}, 32'h1);
    check(req, $sformatf("read %h", a), rdata, exp);
    rready = 1;
    @(posedge clk);
    @(negedge clk);
    rready = 0;
  endtask

  task automatic pulse_ret();
    @(negedge clk); ret = 1;
    @(negedge clk); ret = 0;
    @(negedge clk);
  endtask

  task automatic pulse_halt(input logic [2:0] c, input logic [15:0] id);
    @(negedge clk); halt = 1; err = c; txid = id;
    @(negedge clk); halt = 0;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; awaddr = '0; araddr = '0; wdata = '0;
    awvalid = 0; wvalid = 0; bready = 0; arvalid = 0; rready = 0;
    ret = 0; halt = 0; err = '0; txid = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state at the ports
    check(1, "busy in reset", {31'b0, busy}, 32'h0);
    check(1, "launch in reset", {31'b0, launch}, 32'h0);
    check(1, "bvalid in reset", {31'b0, bvalid}, 32'h0);
    check(1, "rvalid in reset", {31'b0, rvalid}, 32'h0);
    check(1, "coef in reset", coef[31:0] | coef[127:96], 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v = vec_t'(TBL[i]);
      case (v.op)
        OP_WR:   do_wr(int'(v.req), v.addr, v.data);
        OP_RD:   do_rd(int'(v.req), v.addr, v.exp);
        OP_RET:  pulse_ret();
        OP_HALT: pulse_halt(v.data[18:16], v.data[15:0]);
        OP_LCNT: begin @(negedge clk); check(int'(v.req), "launch count", lcnt, v.exp); end
        default: begin @(negedge clk); check(int'(v.req), "busy", {31'b0, busy}, v.exp); end
      endcase
    end

    // R9 coefficients visible on coef_o
    check(9, "coef_o word0", coef[31:0], 32'h11111111);
    check(9, "coef_o word3", coef[127:96], 32'h44444444);

    // R7 halt and clear in the same cycle: halt wins
    @(negedge clk);
    awaddr = 8'h08; wdata = 32'h1; awvalid = 1; wvalid = 1;
    halt = 1; err = 3'd5; txid = 16'h1234;
    @(posedge clk);
    @(negedge clk);
    awvalid = 0; wvalid = 0; halt = 0; bready = 1;
    @(posedge clk);
    @(negedge clk);
    bready = 0;
    do_rd(7, 8'h0C, 32'h1);
    do_rd(7, 8'h10, 32'h5);
    do_rd(7, 8'h14, 32'h1234);
    do_wr(8, 8'h08, 32'h1);
    do_rd(8, 8'h10, 32'h0);
    do_rd(8, 8'h14, 32'h1234);

    // R1 reset while busy returns to idle
    do_wr(2, 8'h00, 32'h1);
    check(2, "launch count before reset", lcnt, 32'h3);
    check(2, "busy before reset", {31'b0, busy}, 32'h1);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check(1, "busy after reset", {31'b0, busy}, 32'h0);
    check(1, "coef after reset", coef[31:0], 32'h0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    do_rd(1, 8'h04, 32'h0);
    check(1, "no launch after reset", lcnt, 32'h3);

    finish_run();
  end
endmodule